// File: doc/BRIEF.md
# Highway and Side-Road Traffic Light Controller

This block sequences the signals at a junction where a busy main highway crosses a rarely used side road. The highway keeps a green light by default. When a sensor reports a vehicle waiting on the side road, the controller hands the junction over through a yellow phase. It gives the side road a green that ends as soon as the road is empty, or when the long interval runs out, whichever comes first. A second yellow phase then returns the junction to the highway.

An interval timer is built into the block. Every phase change sends it a one-cycle restart strobe. The timer then raises a short-interval flag, which times the yellow phases, and a long-interval flag, which times the green phases. Both flags hold until the next restart. The highway therefore always keeps its green for at least the long interval, even while side-road traffic waits.

A parameter selects how the phase register is stored: a 2-bit binary code or a 4-bit one-hot code. The stored code is brought out so that the chosen encoding can be observed.

Top module: `traffic_light_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in highway green with the timer count cleared. While reset is high, the restart strobe is low.
- R2: In highway green, the controller moves to highway yellow only in a cycle where the side-road sensor is high and the long flag is high. In any other cycle it stays in highway green.
- R3: In highway yellow, the controller moves to side-road green in the cycle after the short flag is seen high. Otherwise it holds.
- R4: In side-road green, the controller moves to side-road yellow when the sensor is low or the long flag is high. This includes a cycle where both happen together. It holds only while the sensor is high and the long flag is low.
- R5: In side-road yellow, the controller returns to highway green in the cycle after the short flag is seen high. Otherwise it holds.
- R6: Light codes are green = 2'b00, yellow = 2'b01 and red = 2'b10. The highway shows red in both side-road phases. The side road shows red in both highway phases. The two roads are never non-red at the same time.
- R7: The restart strobe is high for exactly the one cycle before each phase change, and low in every other cycle.
- R8: The short flag is high from the TS_CYC-th rising edge after a strobe (or reset) edge. The long flag is high from the TL_CYC-th such edge. Both stay high until the next strobe edge clears them.
- R9: With ONE_HOT = 0, state_code shows highway green = 4'b0000, highway yellow = 4'b0001, side green = 4'b0011 and side yellow = 4'b0010. With ONE_HOT = 1 it shows 4'b0001, 4'b0010, 4'b0100 and 4'b1000 for the same four phases.
- R10: Every highway green phase lasts at least TL_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_sense | input | 1 | High while a vehicle waits on the side road |
| hwy_light | output | 2 | Highway light code |
| side_light | output | 2 | Side-road light code |
| timer_start | output | 1 | One-cycle interval restart strobe |
| short_done | output | 1 | Short interval elapsed since last restart |
| long_done | output | 1 | Long interval elapsed since last restart |
| state_code | output | 4 | Stored phase code (binary in low two bits, or one-hot) |

## Verification
The side-road green phase has two exit conditions: the sensor going low and the long interval expiring. These can fall in the same cycle. A directed pass holds the sensor high through side-road green, then drops it in exactly the cycle where the bench's own interval count reaches the long limit. The bench then expects a single strobe and a single move to side-road yellow, with no extra cycle and no second strobe. Both outputs are judged against a reference sequence the bench computes itself. A second pair of cases is the restart strobe arriving while the flags are already saturated: the bench checks that both flags drop on the following edge.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_HG = 2'd0,
    PH_HY = 2'd1,
    PH_FG = 2'd2,
    PH_FY = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    LT_GREEN  = 2'b00,
    LT_YELLOW = 2'b01,
    LT_RED    = 2'b10
  } lamp_t;

  function automatic logic [1:0] bin_code(phase_t p);
    case (p)
      PH_HG:   bin_code = 2'b00;
      PH_HY:   bin_code = 2'b01;
      PH_FG:   bin_code = 2'b11;
      default: bin_code = 2'b10;
    endcase
  endfunction

  function automatic phase_t bin_phase(logic [1:0] c);
    case (c)
      2'b00:   bin_phase = PH_HG;
      2'b01:   bin_phase = PH_HY;
      2'b11:   bin_phase = PH_FG;
      default: bin_phase = PH_FY;
    endcase
  endfunction

  function automatic logic [3:0] hot_code(phase_t p);
    case (p)
      PH_HG:   hot_code = 4'b0001;
      PH_HY:   hot_code = 4'b0010;
      PH_FG:   hot_code = 4'b0100;
      default: hot_code = 4'b1000;
    endcase
  endfunction

  function automatic phase_t hot_phase(logic [3:0] c);
    case (c)
      4'b0010: hot_phase = PH_HY;
      4'b0100: hot_phase = PH_FG;
      4'b1000: hot_phase = PH_FY;
      default: hot_phase = PH_HG;
    endcase
  endfunction

  function automatic phase_t next_phase(phase_t p, logic car, logic s_done, logic l_done);
    next_phase = p;
    case (p)
      PH_HG: if (car && l_done) next_phase = PH_HY;
      PH_HY: if (s_done) next_phase = PH_FG;
      PH_FG: if (!car || l_done) next_phase = PH_FY;
      PH_FY: if (s_done) next_phase = PH_HG;
      default: next_phase = PH_HG;
    endcase
  endfunction

  function automatic logic count_reached(int unsigned cnt, int unsigned lim);
    count_reached = (cnt >= lim);
  endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int TS_CYC = 3,
  parameter int TL_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(TL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(TL_CYC);

  logic [CW-1:0] cnt;
  logic          at_max;

  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (!at_max) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign short_done = tlc_pkg::count_reached(32'(cnt), 32'(TS_CYC));
  assign long_done  = tlc_pkg::count_reached(32'(cnt), 32'(TL_CYC));

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer (
  input  logic            rst,
  input  logic            car_sense,
  input  logic            short_done,
  input  logic            long_done,
  input  tlc_pkg::phase_t cur_st,
  output tlc_pkg::phase_t nxt_st,
  output logic            strobe
);
  import tlc_pkg::*;

  phase_t cand;

  always_comb begin
    cand   = next_phase(cur_st, car_sense, short_done, long_done);
    nxt_st = rst ? PH_HG : cand;
    strobe = !rst && (cand != cur_st);
  end

endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  tlc_pkg::phase_t nxt_st,
  output tlc_pkg::phase_t cur_st,
  output logic [3:0]      code
);
  import tlc_pkg::*;

  generate
    if (ONE_HOT) begin : g_hot
      logic [3:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= hot_code(PH_HG);
        else     q <= hot_code(nxt_st);
      end
      assign cur_st = hot_phase(q);
      assign code   = q;
    end else begin : g_bin
      logic [1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= bin_code(PH_HG);
        else     q <= bin_code(nxt_st);
      end
      assign cur_st = bin_phase(q);
      assign code   = {2'b00, q};
    end
  endgenerate

endmodule

// File: rtl/tlc_lamp_map.sv
module tlc_lamp_map (
  input  tlc_pkg::phase_t cur_st,
  output tlc_pkg::lamp_t  hwy,
  output tlc_pkg::lamp_t  side
);
  import tlc_pkg::*;

  always_comb begin
    hwy  = LT_RED;
    side = LT_RED;
    case (cur_st)
      PH_HG: hwy  = LT_GREEN;
      PH_HY: hwy  = LT_YELLOW;
      PH_FG: side = LT_GREEN;
      PH_FY: side = LT_YELLOW;
      default: begin
        hwy  = LT_RED;
        side = LT_RED;
      end
    endcase
  end

endmodule

// File: rtl/traffic_light_ctrl.sv
module traffic_light_ctrl #(
  parameter int TS_CYC  = 3,
  parameter int TL_CYC  = 8,
  parameter bit ONE_HOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_sense,
  output logic [1:0] hwy_light,
  output logic [1:0] side_light,
  output logic       timer_start,
  output logic       short_done,
  output logic       long_done,
  output logic [3:0] state_code
);
  import tlc_pkg::*;

  phase_t cur_st;
  phase_t nxt_st;
  lamp_t  hwy_l;
  lamp_t  side_l;
  logic   restart;

  tlc_interval_timer #(.TS_CYC(TS_CYC), .TL_CYC(TL_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .short_done (short_done),
    .long_done  (long_done)
  );

  tlc_sequencer u_seq (
    .rst        (rst),
    .car_sense  (car_sense),
    .short_done (short_done),
    .long_done  (long_done),
    .cur_st     (cur_st),
    .nxt_st     (nxt_st),
    .strobe     (restart)
  );

  tlc_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (nxt_st),
    .cur_st (cur_st),
    .code   (state_code)
  );

  tlc_lamp_map u_lamp (
    .cur_st (cur_st),
    .hwy    (hwy_l),
    .side   (side_l)
  );

  assign hwy_light   = hwy_l;
  assign side_light  = side_l;
  assign timer_start = restart;

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
  parameter int TL_CYC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            car_sense,
  input logic [1:0]      hwy_light,
  input logic [1:0]      side_light,
  input logic            timer_start,
  input logic            short_done,
  input logic            long_done,
  input tlc_pkg::phase_t cur_st
);
  import tlc_pkg::*;

  int unsigned hg_run;

  always_ff @(posedge clk) begin
    if (rst || timer_start) hg_run <= 0;
    else if (cur_st == PH_HG && hg_run < 32'hFFFF) hg_run <= hg_run + 1;
  end

  // R6
  never_both_go_chk: assert property (@(posedge clk) disable iff (rst)
    !(hwy_light != 2'b10 && side_light != 2'b10));

  // R7
  strobe_moves_chk: assert property (@(posedge clk) disable iff (rst)
    timer_start |=> (cur_st != $past(cur_st)));

  // R7
  quiet_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !timer_start |=> $stable(cur_st));

  // R2
  hg_exit_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_st == PH_HG && timer_start) |-> (car_sense && long_done));

  // R4
  fg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_st == PH_FG && car_sense && !long_done) |-> !timer_start);

  // R8
  long_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (long_done && !timer_start) |=> long_done);

  // R8
  flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    timer_start |=> (!short_done && !long_done));

  // R10
  hg_min_len_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_st == PH_HG && timer_start) |-> (hg_run >= TL_CYC));

endmodule

bind traffic_light_ctrl tlc_checker #(.TL_CYC(TL_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .car_sense   (car_sense),
  .hwy_light   (hwy_light),
  .side_light  (side_light),
  .timer_start (timer_start),
  .short_done  (short_done),
  .long_done   (long_done),
  .cur_st      (cur_st)
);

// File: tb/sim_traffic_light_ctrl.sv
module sim_traffic_light_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TS = 3;
  localparam int TL = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car_sense = 1'b0;
  logic [1:0] hwy0, side0, hwy1, side1;
  logic       ts0, sd0, ld0, ts1, sd1, ld1;
  logic [3:0] code0, code1;

  int n_chk = 0;
  int n_fail = 0;
  int m_st = 0;     // 0 HG, 1 HY, 2 FG, 3 FY
  int m_cnt = 0;
  int hg_len = 0;
  int coincide_hits = 0;
  bit m_valid = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  traffic_light_ctrl #(.TS_CYC(TS), .TL_CYC(TL), .ONE_HOT(1'b0)) u0 (
    .clk(clk), .rst(rst), .car_sense(car_sense), .hwy_light(hwy0), .side_light(side0),
    .timer_start(ts0), .short_done(sd0), .long_done(ld0), .state_code(code0));

  traffic_light_ctrl #(.TS_CYC(TS), .TL_CYC(TL), .ONE_HOT(1'b1)) u1 (
    .clk(clk), .rst(rst), .car_sense(car_sense), .hwy_light(hwy1), .side_light(side1),
    .timer_start(ts1), .short_done(sd1), .long_done(ld1), .state_code(code1));

  function automatic int want_next(int st, bit car, bit s, bit l);
    if (st == 0) return (l && car) ? 1 : 0;
    if (st == 1) return s ? 2 : 1;
    if (st == 2) return (l || !car) ? 3 : 2;
    return s ? 0 : 3;
  endfunction

  function automatic int want_hwy(int st);
    return (st == 0) ? 0 : (st == 1) ? 1 : 2;
  endfunction

  function automatic int want_side(int st);
    return (st == 2) ? 0 : (st == 3) ? 1 : 2;
  endfunction

  function automatic int want_bin(int st);
    int tbl[4] = '{0, 1, 3, 2};
    return tbl[st];
  endfunction

  function automatic int want_hot(int st);
    return 1 << st;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic step(bit car, bit rst_v);
    bit s, l, e_strobe;
    int nx;
    @(negedge clk);
    rst = rst_v;
    car_sense = car;
    #1;
    s = (m_cnt >= TS);
    l = (m_cnt >= TL);
    nx = want_next(m_st, car, s, l);
    e_strobe = !rst_v && (nx != m_st);
    if (m_valid) begin
      chk("R6 hwy_light", int'(hwy0), want_hwy(m_st));
      chk("R6 side_light", int'(side0), want_side(m_st));
      chk("R6 one-hot hwy", int'(hwy1), want_hwy(m_st));
      chk("R6 one-hot side", int'(side1), want_side(m_st));
      chk("R7 timer_start", int'(ts0), int'(e_strobe));
      chk("R7 one-hot timer_start", int'(ts1), int'(e_strobe));
      chk("R8 short_done", int'(sd0), int'(s));
      chk("R8 long_done", int'(ld0), int'(l));
      chk("R8 one-hot flags", int'({sd1, ld1}), int'({s, l}));
      chk("R9 binary code", int'(code0), want_bin(m_st));
      chk("R9 one-hot code", int'(code1), want_hot(m_st));
      if (!rst_v && m_st == 0 && e_strobe) begin
        chk("R2 exit needs car and long", int'(car && l), 1);
        chk("R10 highway green length ok", int'(hg_len >= TL), 1);
      end
      if (!rst_v && m_st == 2 && !car && l) coincide_hits++;
    end
    if (m_st == 0) hg_len++;
    @(posedge clk);
    if (rst_v) begin
      m_st = 0; m_cnt = 0; hg_len = 0; m_valid = 1'b1;
    end else if (e_strobe) begin
      m_st = nx; m_cnt = 0;
      if (nx == 0) hg_len = 0;
    end else if (m_cnt < TL) begin
      m_cnt++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    // R1: reset state
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    chk("R1 reset hwy green", int'(hwy0), 0);
    chk("R1 reset side red", int'(side0), 2);
    chk("R1 reset strobe low", int'(ts0), 0);
    // R2: no car keeps highway green long after the interval
    for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
    chk("R2 stays highway green without car", m_st, 0);
    // R3, R5: car held constantly, side green capped by long interval (R4)
    for (int i = 0; i < 120; i++) step(1'b1, 1'b0);
    // R4: coincident sensor drop and long expiry in side green
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < 200; i++) begin
        if (m_st == 2 && m_cnt == TL) begin
          step(1'b0, 1'b0);
          break;
        end
        step(1'b1, 1'b0);
      end
      step(1'b1, 1'b0);
      chk("R4 coincident exit reaches side yellow", m_st, 3);
    end
    chk("R4 coincidence exercised", int'(coincide_hits > 0), 1);
    // R4: short visit, car vanishes early in side green
    for (int i = 0; i < 60; i++) step((m_st == 2 && m_cnt >= 1) ? 1'b0 : 1'b1, 1'b0);
    // R1: mid-run reset from a non-highway phase
    for (int i = 0; i < 200 && m_st != 2; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk("R1 mid-run reset returns to highway green", int'(hwy0), 0);
    // Random traffic, biased sensor
    for (int i = 0; i < 3000; i++) begin
      bit car = (($urandom % 100) < 55);
      bit r = (($urandom % 1000) == 0);
      step(car, r);
    end
    finish_run();
  end

endmodule